// File: doc/BRIEF.md
# Microcode Sequencer with Step-Counter Rollover

This block produces the microinstruction address for a microcoded processor. The address joins three parts: a page select, an opcode slot and a step counter. Each opcode slot owns sixteen consecutive microsteps. The slot and the step together form one counting field that advances every cycle. A routine that runs past its sixteenth step therefore carries into the microcode of the next slot. After all slots of a page it wraps back to the first slot of the same page. A long routine can thus use many slots' worth of steps until one of its steps leaves the loop.

A step leaves the running sequence by rewriting the opcode slot. The "next" operation loads a freshly fetched opcode slot and page. A jump loads either a literal taken from the microinstruction or a value taken from a register, together with a page. Every load restarts the step count at zero. The block also holds a condition flag that an earlier microstep writes. The flag is presented as the variant select, and it picks which of the two microinstructions stored at each address executes.

Top module: `useq_sequencer`

## Requirements
- R1: After a clock edge with `rst_n` low, `uaddr_o` is all zeros (page 0, slot 0, step 0) and `variant_o` is 0.
- R2: In a cycle with neither `next_i` nor `jump_i`, the low 8 bits of `uaddr_o` (slot in bits 7:4, step in bits 3:0) rise by one at the clock edge, and the page bits above bit 7 stay unchanged.
- R3: When the step is 15 and no load occurs, the next address has step 0 and the slot one higher, in the same page.
- R4: When slot and step are both 15 (low byte 0xFF) and no load occurs, the low byte becomes 0x00 and the page stays unchanged.
- R5: With `jump_i` high, `next_i` low and `jump_src_i` = 0, the next address is {`jump_page_i`, `jump_lit_i`, step 0}.
- R6: With `jump_i` high, `next_i` low and `jump_src_i` = 1, the next address is {`jump_page_i`, `jump_reg_i`, step 0}.
- R7: With `next_i` high, the next address is {`next_page_i`, `next_slot_i`, step 0}. This includes a cycle in which `jump_i` is also high, because `next_i` wins over a jump.
- R8: Any load takes precedence over the increment in the same cycle: after a load the step field is 0, whatever the previous step was.
- R9: With `flag_we_i` high, `variant_o` equals `flag_d_i` after the clock edge. With `flag_we_i` low, `variant_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| next_i | input | 1 | Start a fetched opcode |
| next_slot_i | input | 4 | Opcode slot of the fetched opcode |
| next_page_i | input | 2 | Page for the fetched opcode |
| jump_i | input | 1 | Jump by rewriting the opcode slot |
| jump_src_i | input | 1 | Jump source: 0 literal, 1 register |
| jump_lit_i | input | 4 | Literal jump target slot |
| jump_reg_i | input | 4 | Register jump target slot |
| jump_page_i | input | 2 | Page for a jump |
| flag_we_i | input | 1 | Write the condition flag |
| flag_d_i | input | 1 | Condition flag value |
| uaddr_o | output | 10 | Microinstruction address {page, slot, step} |
| variant_o | output | 1 | Selected microinstruction variant |

## Verification
The assertions assume that every control input is a defined 0 or 1 at each rising edge. They also assume that the load inputs are held stable around the edge, so that the value seen by `$past` is the value that was loaded. The bench changes inputs only at falling edges, which keeps it within both assumptions. It holds `next_i` and `jump_i` low for most random cycles, so the counter reaches the rollover and wrap points. Directed runs drive the counter up to step 15 and to the 0xFF wrap, and set both load requests at once.

// File: rtl/useq_pkg.sv
// Package: shared widths and types for the microcode sequencer.
// Assumes: the slot and step fields together form the counting field.
package useq_pkg;
    // Source of a jump target
    typedef enum logic {
        JSRC_LITERAL  = 1'b0,
        JSRC_REGISTER = 1'b1
    } jump_src_e;
endpackage

// File: rtl/useq_target_sel.sv
// Module: useq_target_sel
// Decides whether the sequencing field is reloaded this cycle, and with which
// slot and page. The fetch operation wins over a jump. A jump takes its slot
// from the literal or from the register, as the source select chooses.
// Assumes: the inputs are stable before the clock edge.
module useq_target_sel
    import useq_pkg::*;
#(
    parameter int PAGE_W = 2,
    parameter int SLOT_W = 4
) (
    input  logic              next_i,
    input  logic [SLOT_W-1:0] next_slot_i,
    input  logic [PAGE_W-1:0] next_page_i,
    input  logic              jump_i,
    input  jump_src_e         jump_src_i,
    input  logic [SLOT_W-1:0] jump_lit_i,
    input  logic [SLOT_W-1:0] jump_reg_i,
    input  logic [PAGE_W-1:0] jump_page_i,
    output logic              load_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic [PAGE_W-1:0] page_o
);
    logic [SLOT_W-1:0] jump_slot;

    // Pick the jump target slot from its source
    always_comb begin
        jump_slot = (jump_src_i == JSRC_REGISTER) ? jump_reg_i : jump_lit_i;
    end

    // Fetch has priority over a jump; either one requests a load
    always_comb begin
        load_o = next_i | jump_i;
        if (next_i) begin
            slot_o = next_slot_i;
            page_o = next_page_i;
        end else begin
            slot_o = jump_slot;
            page_o = jump_page_i;
        end
    end
endmodule

// File: rtl/useq_field_ctr.sv
// Module: useq_field_ctr
// Holds the joined {slot, step} field as one counter. It increments every
// cycle, so a carry out of the step goes into the slot, and the whole field
// wraps to zero. A load writes the slot and clears the step, and it wins
// over the increment.
// Assumes: synchronous active-low reset.
module useq_field_ctr #(
    parameter int SLOT_W = 4,
    parameter int STEP_W = 4,
    localparam int FIELD_W = SLOT_W + STEP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [SLOT_W-1:0]  slot_i,
    output logic [FIELD_W-1:0] field_o
);
    logic [FIELD_W-1:0] field_q;

    // Reset, reload, or advance the sequencing field
    always_ff @(posedge clk) begin
        if (!rst_n)
            field_q <= '0;
        else if (load_i)
            field_q <= {slot_i, {STEP_W{1'b0}}};
        else
            field_q <= field_q + FIELD_W'(1);
    end

    assign field_o = field_q;
endmodule

// File: rtl/useq_page_reg.sv
// Module: useq_page_reg
// Holds the page select. It changes only on a load.
// Assumes: synchronous active-low reset.
module useq_page_reg #(
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [PAGE_W-1:0] page_i,
    output logic [PAGE_W-1:0] page_o
);
    // Capture a new page on a load, otherwise keep it
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_o <= '0;
        else if (load_i)
            page_o <= page_i;
    end
endmodule

// File: rtl/useq_cond_flag.sv
// Module: useq_cond_flag
// Condition flag written by a microstep. It selects which of the two
// microinstruction variants runs in the following steps.
// Assumes: synchronous active-low reset.
module useq_cond_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic we_i,
    input  logic d_i,
    output logic flag_o
);
    // Write the flag when enabled, otherwise hold it
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (we_i)
            flag_o <= d_i;
    end
endmodule

// File: rtl/useq_sequencer.sv
// Module: useq_sequencer (top)
// Microcode address sequencer. The address is {page, slot, step}. The slot
// and the step count together as one field, so a routine that runs past
// its last step continues in the next slot's microcode. Fetch and jump
// rewrite the slot, and they restart the step at zero. The condition flag
// is presented as the variant select.
// Assumes: inputs change away from the rising clock edge.
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int PAGE_W = 2,
    parameter int SLOT_W = 4,
    parameter int STEP_W = 4,
    localparam int FIELD_W = SLOT_W + STEP_W,
    localparam int ADDR_W  = PAGE_W + FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              next_i,
    input  logic [SLOT_W-1:0] next_slot_i,
    input  logic [PAGE_W-1:0] next_page_i,
    input  logic              jump_i,
    input  logic              jump_src_i,
    input  logic [SLOT_W-1:0] jump_lit_i,
    input  logic [SLOT_W-1:0] jump_reg_i,
    input  logic [PAGE_W-1:0] jump_page_i,
    input  logic              flag_we_i,
    input  logic              flag_d_i,
    output logic [ADDR_W-1:0] uaddr_o,
    output logic              variant_o
);
    logic               load;
    logic [SLOT_W-1:0]  load_slot;
    logic [PAGE_W-1:0]  load_page;
    logic [FIELD_W-1:0] field;
    logic [PAGE_W-1:0]  page;

    useq_target_sel #(.PAGE_W(PAGE_W), .SLOT_W(SLOT_W)) u_sel (
        .next_i      (next_i),
        .next_slot_i (next_slot_i),
        .next_page_i (next_page_i),
        .jump_i      (jump_i),
        .jump_src_i  (jump_src_e'(jump_src_i)),
        .jump_lit_i  (jump_lit_i),
        .jump_reg_i  (jump_reg_i),
        .jump_page_i (jump_page_i),
        .load_o      (load),
        .slot_o      (load_slot),
        .page_o      (load_page)
    );

    useq_field_ctr #(.SLOT_W(SLOT_W), .STEP_W(STEP_W)) u_field (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .slot_i  (load_slot),
        .field_o (field)
    );

    useq_page_reg #(.PAGE_W(PAGE_W)) u_page (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .page_i (load_page),
        .page_o (page)
    );

    useq_cond_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (flag_we_i),
        .d_i    (flag_d_i),
        .flag_o (variant_o)
    );

    // Form the microinstruction address
    always_comb begin
        uaddr_o = {page, field};
    end
endmodule

// File: rtl/useq_sequencer_chk.sv
// Module: useq_sequencer_chk
// Checker bound to useq_sequencer. It relates the address and variant
// outputs to the control inputs of the previous cycle.
// Assumes: inputs are stable at each rising edge.
module useq_sequencer_chk #(
    parameter int PAGE_W = 2,
    parameter int SLOT_W = 4,
    parameter int STEP_W = 4,
    localparam int FIELD_W = SLOT_W + STEP_W,
    localparam int ADDR_W  = PAGE_W + FIELD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              next_i,
    input logic [SLOT_W-1:0] next_slot_i,
    input logic [PAGE_W-1:0] next_page_i,
    input logic              jump_i,
    input logic              jump_src_i,
    input logic [SLOT_W-1:0] jump_lit_i,
    input logic [SLOT_W-1:0] jump_reg_i,
    input logic [PAGE_W-1:0] jump_page_i,
    input logic              flag_we_i,
    input logic              flag_d_i,
    input logic [ADDR_W-1:0] uaddr_o,
    input logic              variant_o
);
    logic [FIELD_W-1:0] fld;
    logic [PAGE_W-1:0]  pg;
    assign fld = uaddr_o[FIELD_W-1:0];
    assign pg  = uaddr_o[ADDR_W-1:FIELD_W];

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (uaddr_o == '0 && !variant_o)); // R1

    AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!next_i && !jump_i) |=> (fld == $past(fld) + FIELD_W'(1))); // R2

    AST_IDLE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!next_i && !jump_i) |=> $stable(pg)); // R4

    AST_STEP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!next_i && !jump_i && fld[STEP_W-1:0] == '1)
        |=> (fld[STEP_W-1:0] == '0)); // R3

    AST_JUMP_LIT: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_i && !next_i && !jump_src_i)
        |=> (uaddr_o == {$past(jump_page_i), $past(jump_lit_i), {STEP_W{1'b0}}})); // R5

    AST_JUMP_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_i && !next_i && jump_src_i)
        |=> (uaddr_o == {$past(jump_page_i), $past(jump_reg_i), {STEP_W{1'b0}}})); // R6

    AST_NEXT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        next_i |=> (uaddr_o == {$past(next_page_i), $past(next_slot_i), {STEP_W{1'b0}}})); // R7

    AST_LOAD_STEP0: assert property (@(posedge clk) disable iff (!rst_n)
        (next_i || jump_i) |=> (fld[STEP_W-1:0] == '0)); // R8

    AST_FLAG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_i |=> (variant_o == $past(flag_d_i))); // R9

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_i |=> $stable(variant_o)); // R9
endmodule

bind useq_sequencer useq_sequencer_chk #(
    .PAGE_W(PAGE_W), .SLOT_W(SLOT_W), .STEP_W(STEP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .next_i(next_i), .next_slot_i(next_slot_i),
    .next_page_i(next_page_i), .jump_i(jump_i), .jump_src_i(jump_src_i),
    .jump_lit_i(jump_lit_i), .jump_reg_i(jump_reg_i), .jump_page_i(jump_page_i),
    .flag_we_i(flag_we_i), .flag_d_i(flag_d_i), .uaddr_o(uaddr_o),
    .variant_o(variant_o)
);

// File: tb/sim_useq_sequencer.sv
// Bench for useq_sequencer: directed corner cases, then seeded random
// stimulus, checked against a reference model kept in bench functions.
module sim_useq_sequencer;
    localparam int PAGE_W = 2;
    localparam int SLOT_W = 4;
    localparam int STEP_W = 4;
    localparam int FIELD_W = SLOT_W + STEP_W;
    localparam int ADDR_W = PAGE_W + FIELD_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              next_i = 1'b0;
    logic [SLOT_W-1:0] next_slot_i = '0;
    logic [PAGE_W-1:0] next_page_i = '0;
    logic              jump_i = 1'b0;
    logic              jump_src_i = 1'b0;
    logic [SLOT_W-1:0] jump_lit_i = '0;
    logic [SLOT_W-1:0] jump_reg_i = '0;
    logic [PAGE_W-1:0] jump_page_i = '0;
    logic              flag_we_i = 1'b0;
    logic              flag_d_i = 1'b0;
    logic [ADDR_W-1:0] uaddr_o;
    logic              variant_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [ADDR_W-1:0] m_addr;
    logic              m_var;

    useq_sequencer u0 (.*);

    always #10 clk = ~clk;   // 50 MHz

    // Reference: next address from the current one and the control inputs
    function automatic logic [ADDR_W-1:0] ref_addr(
        input logic [ADDR_W-1:0] cur, input logic nx, input logic [SLOT_W-1:0] ns,
        input logic [PAGE_W-1:0] np, input logic jp, input logic src,
        input logic [SLOT_W-1:0] lit, input logic [SLOT_W-1:0] rg,
        input logic [PAGE_W-1:0] jpg);
        logic [FIELD_W-1:0] f;
        if (nx) return {np, ns, {STEP_W{1'b0}}};
        if (jp) return {jpg, (src ? rg : lit), {STEP_W{1'b0}}};
        f = cur[FIELD_W-1:0] + FIELD_W'(1);
        return {cur[ADDR_W-1:FIELD_W], f};
    endfunction

    // Which requirement a given step exercises
    function automatic string tag_of(input logic [ADDR_W-1:0] cur, input logic nx,
                                     input logic jp, input logic src);
        if (nx && jp) return "R8";
        if (nx) return "R7";
        if (jp) return src ? "R6" : "R5";
        if (cur[FIELD_W-1:0] == '1) return "R4";
        if (cur[STEP_W-1:0] == '1) return "R3";
        return "R2";
    endfunction

    task automatic check_addr(input string tag, input logic [ADDR_W-1:0] exp);
        checks++;
        if (uaddr_o !== exp) begin
            errors++;
            $display("FAIL %s uaddr actual=%h expected=%h", tag, uaddr_o, exp);
        end
    endtask

    task automatic check_var(input logic exp);
        checks++;
        if (variant_o !== exp) begin
            errors++;
            $display("FAIL R9 variant actual=%b expected=%b", variant_o, exp);
        end
    endtask

    // Drive one cycle at a falling edge, then check at the next falling edge
    task automatic cyc(input logic nx, input logic [SLOT_W-1:0] ns,
                       input logic [PAGE_W-1:0] np, input logic jp, input logic src,
                       input logic [SLOT_W-1:0] lit, input logic [SLOT_W-1:0] rg,
                       input logic [PAGE_W-1:0] jpg, input logic we, input logic d);
        string t;
        next_i = nx; next_slot_i = ns; next_page_i = np;
        jump_i = jp; jump_src_i = src; jump_lit_i = lit; jump_reg_i = rg;
        jump_page_i = jpg; flag_we_i = we; flag_d_i = d;
        t = tag_of(m_addr, nx, jp, src);
        m_addr = ref_addr(m_addr, nx, ns, np, jp, src, lit, rg, jpg);
        if (we) m_var = d;
        @(negedge clk);
        check_addr(t, m_addr);
        check_var(m_var);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check_addr("R1", '0);
        checks++;
        if (variant_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 variant actual=%b expected=0", variant_o);
        end
        m_addr = '0;
        m_var = 1'b0;
        rst_n = 1'b1;

        // R2, R3: count through slot 0 and carry into slot 1
        idle(17);
        // R7: fetch into page 2, slot 0xE, then run to the 0xFF wrap (R4)
        cyc(1, 4'hE, 2'd2, 0, 0, 0, 0, 0, 0, 0);
        idle(33);
        // R5: literal jump; R6: register jump
        cyc(0, 0, 0, 1, 0, 4'h2, 4'h9, 2'd1, 0, 0);
        idle(5);
        cyc(0, 0, 0, 1, 1, 4'h2, 4'h9, 2'd3, 0, 0);
        // R8: fetch and jump in the same cycle, fetch wins
        idle(7);
        cyc(1, 4'h5, 2'd0, 1, 0, 4'hA, 4'hB, 2'd3, 0, 0);
        // R9: both flag values, then hold
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);

        // Random phase: mostly idle so rollover and wrap occur
        for (int k = 0; k < 3000; k++) begin
            logic nx, jp;
            nx = ($urandom % 20) == 0;
            jp = ($urandom % 15) == 0;
            cyc(nx, SLOT_W'($urandom), PAGE_W'($urandom), jp, 1'($urandom),
                SLOT_W'($urandom), SLOT_W'($urandom), PAGE_W'($urandom),
                ($urandom % 4) == 0, 1'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule